// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a requester and a byte-addressed memory. It gives each bit of two backing regions its own word-sized alias address. Each window spans 32 MB of alias space. A read through an alias fetches the backing data and returns the addressed bit alone. A write through an alias turns into a read of the backing data, a change to that single bit, and a write of the result back to the same place.

Requests arrive on a valid/ready port, and the bridge takes one at a time. The bridge runs the backing accesses on its master port, then returns a one-cycle response that carries data and an error flag. Errors from the memory pass back to the requester. A global enable lets a system switch the alias decode off. The bridge does not keep any memory contents.

Top module: `bitband_bridge`

## Requirements
- R1: Alias window 0x22000000–0x23FFFFFF maps onto backing memory at 0x20000000, and window 0x42000000–0x43FFFFFF maps onto 0x40000000. Any other request address gets an error response with rdata zero and causes no master-port request.
- R2: The request size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The backing address is the window's backing base ORed with alias offset bits [24:5], then rounded down to a multiple of the access size. The master port uses the same size code.
- R3: Within the fetched data, the selected bit is alias offset bits [6:2] masked to (8×bytes−1). Data lanes are little-endian: byte address A sits in bus bits [8·A[1:0]+7 : 8·A[1:0]]. The byte enables have one bit set for each accessed byte lane, counted from the aligned backing address.
- R4: A good alias read returns the selected backing bit in response bit 0, and all other response bits are zero.
- R5: An alias write reads the backing data and then writes it back at the same address and size. In the write-back, the selected bit equals write-data bit 0 and every other enabled bit keeps the value just read. A master request is held stable until it is accepted.
- R6: If the backing read of an alias write returns an error, no write-back is issued and the response carries the error with rdata zero.
- R7: An error on an alias read, or on the write-back, is returned as a response error with rdata zero. A successful write returns rdata zero with no error.
- R8: While the enable input is low, every request gets an error response in the cycle after it is accepted, and no master request is made.
- R9: Size code 3 is illegal. It gets an error response and no master request.
- R10: Only one transaction is outstanding. The request ready signal is high only when the bridge is idle, and the response valid signal is a single-cycle pulse.
- R11: After reset, request ready is high, and the response valid and master request valid signals are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Alias decode enable |
| sReqValid | input | 1 | Requester request valid |
| sReqReady | output | 1 | Bridge ready to accept (idle) |
| sReqAddr | input | 32 | Alias byte address |
| sReqWrite | input | 1 | 1 = write |
| sReqSize | input | 2 | Size code 0/1/2 = 1/2/4 bytes |
| sReqWdata | input | 32 | Write data, bit 0 is the new bit value |
| sRspValid | output | 1 | One-cycle response pulse |
| sRspRdata | output | 32 | Response data |
| sRspErr | output | 1 | Response error |
| mReqValid | output | 1 | Master request valid |
| mReqReady | input | 1 | Memory accepts request |
| mReqAddr | output | 32 | Backing byte address (size aligned) |
| mReqWrite | output | 1 | 1 = write-back |
| mReqSize | output | 2 | Size code as on the request |
| mReqBe | output | 4 | Byte-lane enables |
| mReqWdata | output | 32 | Write-back word |
| mRspValid | input | 1 | Memory response valid |
| mRspRdata | input | 32 | Memory read word, little-endian lanes |
| mRspErr | input | 1 | Memory error |

## Verification
The assertions assume that the requester holds its request until it sees ready, and that it takes each response pulse without back-pressure. They also assume that the memory returns exactly one single-cycle response for each accepted master request, and only after that request was accepted. The bench's memory model gives at most one response per request and adds a latency of zero to two cycles. It also varies its request ready on a fixed pattern. The requester side drives one request and waits for its response before issuing the next one.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_RESP
  } ctrlState_t;

  typedef struct packed {
    logic loadReq;
    logic loadRdRsp;
    logic loadWrRsp;
  } dpStrobe_t;
endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sReqValid,
  output logic       sReqReady,
  output logic       sRspValid,
  input  logic       reqHit,
  input  logic       reqIsWrite,
  output logic       mReqValid,
  output logic       mReqWrite,
  input  logic       mReqReady,
  input  logic       mRspValid,
  input  logic       mRspErr,
  output dpStrobe_t  strb
);
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: if (sReqValid) begin
        strb.loadReq = 1'b1;
        stateNext = reqHit ? ST_RD_REQ : ST_RESP;
      end
      ST_RD_REQ:  if (mReqReady) stateNext = ST_RD_WAIT;
      ST_RD_WAIT: if (mRspValid) begin
        strb.loadRdRsp = 1'b1;
        stateNext = (reqIsWrite && !mRspErr) ? ST_WR_REQ : ST_RESP;
      end
      ST_WR_REQ:  if (mReqReady) stateNext = ST_WR_WAIT;
      ST_WR_WAIT: if (mRspValid) begin
        strb.loadWrRsp = 1'b1;
        stateNext = ST_RESP;
      end
      ST_RESP:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign sReqReady = (state == ST_IDLE);
  assign sRspValid = (state == ST_RESP);
  assign mReqValid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mReqWrite = (state == ST_WR_REQ);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    sReqValid && sReqReady |=> !sReqReady); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sRspValid |=> !sRspValid); // R10
  AST_WB_AFTER_GOOD_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mReqValid && mReqWrite) |-> $past(mRspValid && !mRspErr)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid && !mReqReady |=> mReqValid && $stable(mReqWrite)); // R5
endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_NUM = 2,
  parameter int OFF_W   = 25,
  parameter logic [WIN_NUM*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [WIN_NUM*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] sReqAddr,
  input  logic              sReqWrite,
  input  logic [1:0]        sReqSize,
  input  logic [31:0]       sReqWdata,
  input  dpStrobe_t         strb,
  output logic              reqHit,
  output logic              reqIsWrite,
  output logic [ADDR_W-1:0] mReqAddr,
  output logic [1:0]        mReqSize,
  output logic [3:0]        mReqBe,
  output logic [31:0]       mReqWdata,
  input  logic [31:0]       mRspRdata,
  input  logic              mRspErr,
  output logic [31:0]       sRspRdata,
  output logic              sRspErr
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [WIN_NUM-1:0] winHit;
  logic [ADDR_W-1:0]  selBack, rawAddr, alignAddr;
  logic [1:0]         sizeMask;
  logic [3:0]         beBase;
  logic [4:0]         bitPos, laneBit;
  logic               sizeOk, wbit;

  for (genvar g = 0; g < WIN_NUM; g++) begin : gWin
    assign winHit[g] = enable &&
      (sReqAddr[ADDR_W-1:OFF_W] == ALIAS_BASES[g*ADDR_W+OFF_W +: TAG_W]);
  end

  always_comb begin
    selBack = '0;
    for (int i = 0; i < WIN_NUM; i++)
      if (winHit[i]) selBack = selBack | BACK_BASES[i*ADDR_W +: ADDR_W];
  end

  always_comb begin
    unique case (sReqSize)
      2'd0:    begin sizeMask = 2'b00; beBase = 4'b0001; end
      2'd1:    begin sizeMask = 2'b01; beBase = 4'b0011; end
      default: begin sizeMask = 2'b11; beBase = 4'b1111; end
    endcase
  end

  assign sizeOk    = (sReqSize != 2'd3);
  assign reqHit    = (|winHit) && sizeOk;
  assign rawAddr   = selBack | ADDR_W'(sReqAddr[OFF_W-1:0] >> 5);
  assign alignAddr = rawAddr & ~ADDR_W'(sizeMask);
  assign bitPos    = 5'(sReqAddr[OFF_W-1:0] >> 2) & {sizeMask, 3'b111};
  assign laneBit   = {alignAddr[1:0], 3'b000} + bitPos;
  assign wbit      = (sReqWdata & 32'd1) != 32'd0;

  logic [4:0]  bitQ;
  logic        wbitQ;
  logic [31:0] wordQ, rspData;
  logic        rspErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mReqAddr   <= '0;
      mReqSize   <= '0;
      mReqBe     <= '0;
      bitQ       <= '0;
      wbitQ      <= 1'b0;
      reqIsWrite <= 1'b0;
      wordQ      <= '0;
      rspData    <= '0;
      rspErr     <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        mReqAddr   <= alignAddr;
        mReqSize   <= sReqSize;
        mReqBe     <= beBase << alignAddr[1:0];
        bitQ       <= laneBit;
        wbitQ      <= wbit;
        reqIsWrite <= sReqWrite;
        rspData    <= '0;
        rspErr     <= !reqHit;
      end
      if (strb.loadRdRsp) begin
        rspErr  <= mRspErr;
        rspData <= {31'b0, !mRspErr && mRspRdata[bitQ]};
        wordQ   <= wbitQ ? (mRspRdata | (32'd1 << bitQ))
                         : (mRspRdata & ~(32'd1 << bitQ));
      end
      if (strb.loadWrRsp) begin
        rspErr  <= mRspErr;
        rspData <= '0;
      end
    end
  end

  assign mReqWdata = wordQ;
  assign sRspRdata = rspData;
  assign sRspErr   = rspErr;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadReq |=> $stable(mReqAddr)); // R2
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRdRsp && mRspErr |=> sRspErr && sRspRdata == 32'd0); // R7
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_NUM = 2,
  parameter int OFF_W   = 25,
  parameter logic [WIN_NUM*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [WIN_NUM*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sReqValid,
  output logic              sReqReady,
  input  logic [ADDR_W-1:0] sReqAddr,
  input  logic              sReqWrite,
  input  logic [1:0]        sReqSize,
  input  logic [31:0]       sReqWdata,
  output logic              sRspValid,
  output logic [31:0]       sRspRdata,
  output logic              sRspErr,
  output logic              mReqValid,
  input  logic              mReqReady,
  output logic [ADDR_W-1:0] mReqAddr,
  output logic              mReqWrite,
  output logic [1:0]        mReqSize,
  output logic [3:0]        mReqBe,
  output logic [31:0]       mReqWdata,
  input  logic              mRspValid,
  input  logic [31:0]       mRspRdata,
  input  logic              mRspErr
);
  dpStrobe_t strb;
  logic reqHit, reqIsWrite;

  bb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sReqValid(sReqValid), .sReqReady(sReqReady), .sRspValid(sRspValid),
    .reqHit(reqHit), .reqIsWrite(reqIsWrite),
    .mReqValid(mReqValid), .mReqWrite(mReqWrite), .mReqReady(mReqReady),
    .mRspValid(mRspValid), .mRspErr(mRspErr), .strb(strb)
  );

  bb_datapath #(
    .ADDR_W(ADDR_W), .WIN_NUM(WIN_NUM), .OFF_W(OFF_W),
    .ALIAS_BASES(ALIAS_BASES), .BACK_BASES(BACK_BASES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sReqAddr(sReqAddr), .sReqWrite(sReqWrite), .sReqSize(sReqSize),
    .sReqWdata(sReqWdata), .strb(strb),
    .reqHit(reqHit), .reqIsWrite(reqIsWrite),
    .mReqAddr(mReqAddr), .mReqSize(mReqSize), .mReqBe(mReqBe),
    .mReqWdata(mReqWdata), .mRspRdata(mRspRdata), .mRspErr(mRspErr),
    .sRspRdata(sRspRdata), .sRspErr(sRspErr)
  );

  AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    sReqValid && sReqReady && !enable |=> sRspValid && sRspErr); // R8
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    mReqValid |-> $countones(mReqBe) == (1 << mReqSize)); // R3
endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b1;
  logic sReqValid = 1'b0, sReqWrite = 1'b0;
  logic [31:0] sReqAddr = '0, sReqWdata = '0;
  logic [1:0] sReqSize = '0;
  logic sReqReady, sRspValid, sRspErr;
  logic [31:0] sRspRdata;
  logic mReqValid, mReqWrite;
  logic mReqReady = 1'b1, mRspValid = 1'b0, mRspErr = 1'b0;
  logic [31:0] mReqAddr, mReqWdata, mRspRdata = '0;
  logic [1:0] mReqSize;
  logic [3:0] mReqBe;

  always #5 clk = ~clk;

  bitband_bridge u_bitband_bridge (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sReqValid(sReqValid), .sReqReady(sReqReady), .sReqAddr(sReqAddr),
    .sReqWrite(sReqWrite), .sReqSize(sReqSize), .sReqWdata(sReqWdata),
    .sRspValid(sRspValid), .sRspRdata(sRspRdata), .sRspErr(sRspErr),
    .mReqValid(mReqValid), .mReqReady(mReqReady), .mReqAddr(mReqAddr),
    .mReqWrite(mReqWrite), .mReqSize(mReqSize), .mReqBe(mReqBe),
    .mReqWdata(mReqWdata), .mRspValid(mRspValid), .mRspRdata(mRspRdata),
    .mRspErr(mRspErr)
  );

  int compared = 0, mismatched = 0, cyc = 0, masterCnt = 0;
  bit finished = 0;
  logic [7:0] mem [int unsigned];

  // expected transaction context
  logic [31:0] expAddr; logic [1:0] expSize; logic [3:0] expBe;
  logic [31:0] tgtByte; int tgtBit; bit expWbit;
  logic [32:0] rspQ [$];
  string tagQ [$];

  function automatic logic [7:0] memRd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'((a * 37) ^ (a >> 8) ^ 8'h5A);
  endfunction

  function automatic void check(bit ok, string tag, string what,
                                logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic bit rdErrAt(logic [31:0] a); return a[31:8] == 24'h200001; endfunction
  function automatic bit wrErrAt(logic [31:0] a); return a[31:8] == 24'h400002; endfunction

  // memory model on the master port
  bit pend = 0; int dly = 0; logic [31:0] pData; bit pErr;
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      mRspValid = 0; pend = 0;
    end else begin
      mRspValid = 0;
      if (pend) begin
        if (dly == 0) begin
          mRspValid = 1; mRspRdata = pData; mRspErr = pErr; pend = 0;
        end else dly--;
      end
      mReqReady = (cyc % 4) != 1;
      if (!pend && mReqValid && mReqReady) begin
        logic [31:0] wb;
        masterCnt++;
        wb = {mReqAddr[31:2], 2'b00};
        check(mReqAddr == expAddr, "R2", "master address", mReqAddr, expAddr);
        check(mReqSize == expSize, "R2", "master size", 32'(mReqSize), 32'(expSize));
        check(mReqBe == expBe, "R3", "byte enables", 32'(mReqBe), 32'(expBe));
        check(mReqWrite == (masterCnt == 2), "R5", "master write flag",
              32'(mReqWrite), 32'(masterCnt == 2));
        if (mReqWrite) begin
          pErr = wrErrAt(mReqAddr); pData = '0;
          for (int k = 0; k < 4; k++) if (expBe[k]) begin
            logic [7:0] eb;
            eb = memRd(wb + k);
            if (wb + k == tgtByte) eb[tgtBit] = expWbit;
            check(mReqWdata[8*k +: 8] == eb, "R5", "write-back lane",
                  32'(mReqWdata[8*k +: 8]), 32'(eb));
            if (!pErr) mem[wb + k] = mReqWdata[8*k +: 8];
          end
        end else begin
          pErr = rdErrAt(mReqAddr);
          for (int k = 0; k < 4; k++) pData[8*k +: 8] = memRd(wb + k);
          if (pErr) pData = 32'hDEAD_BEEF;
        end
        pend = 1; dly = cyc % 3;
      end
    end
  end

  // per-clock response comparison against the expected queue
  always @(negedge clk) begin
    if (rstN && sRspValid) begin
      if (rspQ.size() == 0) check(0, "R10", "unexpected response", 32'd1, 32'd0);
      else begin
        logic [32:0] e; string t;
        e = rspQ.pop_front(); t = tagQ.pop_front();
        check(sRspErr == e[32], t, "response error", 32'(sRspErr), 32'(e[32]));
        check(sRspRdata == e[31:0], t, "response data", sRspRdata, e[31:0]);
      end
    end
  end

  task automatic issue(logic [31:0] a, bit wr, logic [1:0] sz, bit wb, string tag);
    bit hit, re, we; int n, expCnt; logic [31:0] base; logic [32:0] e;
    hit = enable && (a[31:25] == 7'h11 || a[31:25] == 7'h21) && sz != 2'd3;
    base = a[30] ? 32'h4000_0000 : 32'h2000_0000;
    tgtByte = base | 32'(a[24:5]); tgtBit = int'(a[4:2]);
    n = 1 << sz;
    expAddr = tgtByte & ~32'(n - 1); expSize = sz; expWbit = wb;
    expBe = 4'(((1 << n) - 1) << expAddr[1:0]);
    re = rdErrAt(expAddr); we = wrErrAt(expAddr);
    if (!hit)     begin e = {1'b1, 32'd0}; expCnt = 0; end
    else if (re)  begin e = {1'b1, 32'd0}; expCnt = 1; end
    else if (!wr) begin e = {1'b0, 31'd0, memRd(tgtByte)[tgtBit]}; expCnt = 1; end
    else          begin e = {we, 32'd0}; expCnt = 2; end
    rspQ.push_back(e); tagQ.push_back(tag);
    masterCnt = 0;
    @(negedge clk);
    sReqValid = 1; sReqAddr = a; sReqWrite = wr; sReqSize = sz;
    sReqWdata = {31'h2AAA_AAAA, wb};
    while (!sReqReady) @(negedge clk);
    @(negedge clk);
    sReqValid = 0;
    check(!sReqReady || sRspValid, "R10", "ready low while busy", 32'(sReqReady), 32'd0);
    while (!sRspValid) @(negedge clk);
    check(masterCnt == expCnt, tag, "master request count", 32'(masterCnt), 32'(expCnt));
  endtask

  function automatic logic [31:0] alias0(logic [31:0] byteAddr, int b);
    return 32'h2200_0000 + ((byteAddr - 32'h2000_0000) << 5) + 32'(b << 2);
  endfunction
  function automatic logic [31:0] alias1(logic [31:0] byteAddr, int b);
    return 32'h4200_0000 + ((byteAddr - 32'h4000_0000) << 5) + 32'(b << 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(sReqReady == 1, "R11", "ready after reset", 32'(sReqReady), 1);
    check(sRspValid == 0, "R11", "rsp valid after reset", 32'(sRspValid), 0);
    check(mReqValid == 0, "R11", "master valid after reset", 32'(mReqValid), 0);
    rstN = 1;
    // reads, all sizes, both windows
    issue(alias0(32'h2000_0013, 5), 0, 2'd2, 0, "R4");
    issue(alias0(32'h2000_0022, 0), 0, 2'd1, 0, "R3");
    issue(alias1(32'h4000_0047, 7), 0, 2'd0, 0, "R1");
    issue(alias1(32'h4000_0ABD, 3), 0, 2'd2, 0, "R2");
    // writes set/clear then read back
    issue(alias0(32'h2000_0031, 6), 1, 2'd2, 1, "R5");
    issue(alias0(32'h2000_0031, 6), 0, 2'd0, 0, "R5");
    issue(alias0(32'h2000_0031, 6), 1, 2'd1, 0, "R5");
    issue(alias0(32'h2000_0031, 6), 0, 2'd2, 0, "R5");
    issue(alias1(32'h4000_0100, 2), 1, 2'd0, 1, "R5");
    issue(alias1(32'h4000_0100, 2), 0, 2'd0, 0, "R4");
    // error paths
    issue(alias0(32'h2000_0105, 1), 0, 2'd2, 0, "R7");
    issue(alias0(32'h2000_0106, 4), 1, 2'd1, 1, "R6");
    issue(alias1(32'h4000_0203, 5), 1, 2'd0, 1, "R7");
    issue(alias1(32'h4000_0203, 5), 0, 2'd0, 0, "R7");
    // decode misses
    issue(32'h2400_0010, 0, 2'd2, 0, "R1");
    issue(32'h2000_0010, 1, 2'd2, 1, "R1");
    issue(alias0(32'h2000_0040, 1), 0, 2'd3, 0, "R9");
    enable = 0;
    issue(alias0(32'h2000_0040, 1), 0, 2'd2, 0, "R8");
    issue(alias1(32'h4000_0040, 1), 1, 2'd0, 1, "R8");
    enable = 1;
    // pseudo-random mix
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r, a;
      r = 32'(i) * 32'h9E37_79B9 ^ 32'(i << 7);
      a = r[0] ? alias1(32'h4000_0000 | 32'(r[11:4]), int'(r[14:12]))
               : alias0(32'h2000_0000 | 32'(r[11:4]), int'(r[14:12]));
      issue(a, r[15], 2'(r[17:16] % 3), r[18], "R10");
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule